// File: doc/BRIEF.md
# LCD Common Scan and Blink Timing Generator

This block derives all row-rate timing for a multiplexed dot-matrix LCD driver from a single master clock. It steps through the common (row) electrodes one at a time and holds each for a fixed number of clocks. It presents the active common both as a one-hot select and as a binary row index, which the segment path uses to fetch the matching font row. At the start of every common period it pulses a latch strobe, so that the segment shift register contents move into the output latch.

The multiplex ratio is chosen by a level input. With that input high, nine commons are scanned: one character line, the cursor row and the annunciator row. With it low, seventeen commons are scanned: two character lines, each with its cursor row, plus the annunciator row. The segment side is 80 columns wide, which is 16 characters of 5 dots. A frame-inversion signal flips at every frame boundary to give AC drive. A slower blink phase flips once every 32 frames. A synchronous active-low reset restarts the scan at common 1 at the start of a frame and clears both phase signals. The duty input may change while the block runs; the new ratio takes effect at the next common boundary.

Top module: `lcd_scan_timing`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state returns to the start of a frame. After that edge, `com_sel` = 17'h00001, `row_idx` = 0, `seg_latch` = 1, `frame_inv` = 0 and `blink_on` = 0.
- R2: `com_sel` always has exactly one bit set, and that bit is bit number `row_idx`. Bit 0 is common 1.
- R3: Each common stays selected for 64 consecutive clocks. Then `row_idx` advances by one, unless the frame ends.
- R4: `seg_latch` is high for exactly the first clock of each common period and low for the other 63.
- R5: With `duty_nine` = 0, a frame scans `row_idx` 0 to 16 and lasts 1088 clocks.
- R6: With `duty_nine` = 1, a frame scans `row_idx` 0 to 8 and lasts 576 clocks. `com_sel[16:9]` stay 0.
- R7: `frame_inv` toggles at every frame boundary, on the clock where `row_idx` returns to 0, and holds otherwise.
- R8: `blink_on` toggles once every 32 frames and holds between those points.
- R9: Suppose `duty_nine` becomes 1 while `row_idx` is above 8. At the end of the current common period the scan returns to `row_idx` 0, and that counts as a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_nine | input | 1 | 1: nine-common scan, 0: seventeen-common scan |
| com_sel | output | 17 | One-hot active common, bit 0 = common 1 |
| row_idx | output | 5 | Binary index of the active common |
| seg_latch | output | 1 | One-clock strobe at the start of each common period |
| frame_inv | output | 1 | AC drive polarity, flips each frame |
| blink_on | output | 1 | Blink phase, flips every 32 frames |

## Verification
The first long run holds seventeen-common duty. It measures the spacing of `frame_inv` edges against 1088 clocks and the spacing of `blink_on` edges against 32 frames. This separates a wrong frame length from a wrong blink divider. A second long run holds nine-common duty, which exposes any scan that leaks onto commons 10 to 17 or keeps the long frame length. A directed switch at row 12 forces the early wrap of R9. A random phase then flips the duty and pulses reset at arbitrary points, and a cycle-by-cycle reference model catches ordering faults at those points.

// File: rtl/lcd_scan_pkg.sv
// Shared types for the LCD scan timing block.
package lcd_scan_pkg;

    // Events raised by the common timer once per clock
    typedef struct packed {
        logic period_start;   // first clock of a common period
        logic frame_end;      // last clock of the last common in a frame
    } scan_evt_t;

endpackage

// File: rtl/lcd_com_timer.sv
// Common period timer and row counter.
// Counts CLKS clocks per common and steps the row index. It wraps to row 0
// when the last row of the selected duty finishes. The duty level is sampled
// only at the end of a common period.
// Assumes CLKS >= 2 and N_SHORT <= N_FULL.
module lcd_com_timer
    import lcd_scan_pkg::*;
#(
    parameter int N_FULL  = 17,
    parameter int N_SHORT = 9,
    parameter int CLKS    = 64,
    parameter int TW      = 6,
    parameter int RW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          short_mode,
    output logic [RW-1:0] row,
    output scan_evt_t     evt
);
    localparam logic [TW-1:0] TICK_LAST  = TW'(CLKS - 1);
    localparam logic [RW-1:0] ROW_LAST_F = RW'(N_FULL - 1);
    localparam logic [RW-1:0] ROW_LAST_S = RW'(N_SHORT - 1);

    logic [TW-1:0] tick;
    logic [RW-1:0] row_last;
    logic          period_end;

    // Pick the final row for the current duty
    always_comb row_last = short_mode ? ROW_LAST_S : ROW_LAST_F;

    assign period_end       = (tick == TICK_LAST);
    assign evt.period_start = (tick == '0);
    assign evt.frame_end    = period_end && (row >= row_last);

    // Advance the clock-within-common counter
    always_ff @(posedge clk) begin
        if (!rst_n)          tick <= '0;
        else if (period_end) tick <= '0;
        else                 tick <= tick + 1'b1;
    end

    // Step the row at each period end, wrap at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)              row <= '0;
        else if (evt.frame_end)  row <= '0;
        else if (period_end)     row <= row + 1'b1;
    end

    // R3: the row holds everywhere except across a period end
    a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != TICK_LAST) |=> $stable(row));

    // R5: the row never leaves the seventeen-common range
    a_r5_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        row <= ROW_LAST_F);

    // R9: a frame end always restarts the scan at common 1
    a_r9_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        evt.frame_end |=> (row == '0));

    // R4: a new period starts right after each period end
    a_r4_period_follows: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> evt.period_start);
endmodule

// File: rtl/lcd_frame_phase.sv
// Frame-rate phase generator.
// Flips the AC inversion at every frame end. It counts frames and flips the
// blink phase after every FRAMES of them.
// Assumes frame_end is a one-clock pulse.
module lcd_frame_phase #(
    parameter int FRAMES = 32,
    parameter int FW     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    output logic inv,
    output logic blink
);
    localparam logic [FW-1:0] FCNT_LAST = FW'(FRAMES - 1);

    logic [FW-1:0] fcnt;
    logic          blink_due;

    assign blink_due = frame_end && (fcnt == FCNT_LAST);

    // Toggle drive polarity once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)         inv <= 1'b0;
        else if (frame_end) inv <= ~inv;
    end

    // Count frames toward the next blink flip
    always_ff @(posedge clk) begin
        if (!rst_n)         fcnt <= '0;
        else if (blink_due) fcnt <= '0;
        else if (frame_end) fcnt <= fcnt + 1'b1;
    end

    // Flip the blink phase when the frame count completes
    always_ff @(posedge clk) begin
        if (!rst_n)         blink <= 1'b0;
        else if (blink_due) blink <= ~blink;
    end

    // R7: inversion flips on every frame end
    a_r7_inv_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (inv != $past(inv)));

    // R7: inversion holds between frame ends
    a_r7_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(inv));

    // R8: the blink phase can only move on a frame end
    a_r8_blink_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(blink));
endmodule

// File: rtl/lcd_scan_timing.sv
// LCD common scan and blink timing generator (top).
// Combines the common timer and the frame phase generator. It decodes the
// row into a one-hot common select and brings out the latch strobe.
// Assumes duty_nine is a level that may change at any clock.
module lcd_scan_timing
    import lcd_scan_pkg::*;
#(
    parameter int N_FULL       = 17,
    parameter int N_SHORT      = 9,
    parameter int CLKS_PER_COM = 64,
    parameter int BLINK_FRAMES = 32,
    parameter int ROW_W        = $clog2(N_FULL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_nine,
    output logic [N_FULL-1:0] com_sel,
    output logic [ROW_W-1:0]  row_idx,
    output logic              seg_latch,
    output logic              frame_inv,
    output logic              blink_on
);
    localparam int TICK_W = (CLKS_PER_COM > 1) ? $clog2(CLKS_PER_COM) : 1;
    localparam int FCNT_W = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

    scan_evt_t        evt;
    logic [ROW_W-1:0] row;

    lcd_com_timer #(
        .N_FULL (N_FULL),
        .N_SHORT(N_SHORT),
        .CLKS   (CLKS_PER_COM),
        .TW     (TICK_W),
        .RW     (ROW_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_mode(duty_nine),
        .row       (row),
        .evt       (evt)
    );

    lcd_frame_phase #(
        .FRAMES(BLINK_FRAMES),
        .FW    (FCNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_end(evt.frame_end),
        .inv      (frame_inv),
        .blink    (blink_on)
    );

    // Decode the row into one select line per common
    for (genvar i = 0; i < N_FULL; i++) begin : g_com
        assign com_sel[i] = (row == ROW_W'(i));
    end

    assign row_idx   = row;
    assign seg_latch = evt.period_start;

    // R2: exactly one common is active at all times
    a_r2_one_common: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_sel) == 1);

    // R4: the latch strobe lasts a single clock
    a_r4_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
        seg_latch |=> !seg_latch);

    // R6: in short duty with a short row, the upper commons stay dark
    a_r6_upper_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_nine && (row < ROW_W'(N_SHORT))) |-> (com_sel[N_FULL-1:N_SHORT] == '0));
endmodule

// File: tb/lcd_scan_timing_test.sv
`timescale 1ns/1ps
module lcd_scan_timing_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        duty_nine = 1'b0;
    logic [16:0] com_sel;
    logic [4:0]  row_idx;
    logic        seg_latch, frame_inv, blink_on;

    always #2.5 clk = ~clk;

    lcd_scan_timing uut (
        .clk(clk), .rst_n(rst_n), .duty_nine(duty_nine),
        .com_sel(com_sel), .row_idx(row_idx), .seg_latch(seg_latch),
        .frame_inv(frame_inv), .blink_on(blink_on)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state, advanced from the requirements
    int   m_tick = 0, m_row = 0, m_frames = 0;
    logic m_inv = 1'b0, m_blink = 1'b0;

    // period measurement state
    int   frame_len = 0, blink_len = 0;
    string meas_req = "R5";
    int   last_inv_cyc = -1, last_blk_cyc = -1;
    logic prev_inv = 1'b0, prev_blk = 1'b0;

    function automatic logic [16:0] exp_sel(int r);
        return 17'(1) << r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // one clock: advance the model at the edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            m_tick = 0; m_row = 0; m_frames = 0; m_inv = 0; m_blink = 0;
        end else if (m_tick == 63) begin
            m_tick = 0;
            if (m_row >= (duty_nine ? 8 : 16)) begin
                m_row = 0;
                m_inv = ~m_inv;
                if (m_frames == 31) begin m_frames = 0; m_blink = ~m_blink; end
                else m_frames++;
            end else m_row++;
        end else m_tick++;
        @(negedge clk);
        check(com_sel == exp_sel(m_row), "R2", "com_sel", int'(com_sel), int'(exp_sel(m_row)));
        check(int'(row_idx) == m_row, "R3", "row_idx", int'(row_idx), m_row);
        check(seg_latch == (m_tick == 0), "R4", "seg_latch", int'(seg_latch), int'(m_tick == 0));
        check(frame_inv == m_inv, "R7", "frame_inv", int'(frame_inv), int'(m_inv));
        check(blink_on == m_blink, "R8", "blink_on", int'(blink_on), int'(m_blink));
        if (duty_nine && m_row < 9)
            check(com_sel[16:9] == '0, "R6", "upper commons", int'(com_sel[16:9]), 0);
        if (frame_inv != prev_inv) begin
            if (frame_len > 0 && last_inv_cyc >= 0)
                check(cyc - last_inv_cyc == frame_len, meas_req, "frame length",
                      cyc - last_inv_cyc, frame_len);
            last_inv_cyc = cyc;
        end
        if (blink_on != prev_blk) begin
            if (blink_len > 0 && last_blk_cyc >= 0)
                check(cyc - last_blk_cyc == blink_len, "R8", "blink period",
                      cyc - last_blk_cyc, blink_len);
            last_blk_cyc = cyc;
        end
        prev_inv = frame_inv;
        prev_blk = blink_on;
    endtask

    task automatic check_reset_state();
        check(com_sel == 17'h00001, "R1", "com_sel after reset", int'(com_sel), 1);
        check(row_idx == 5'd0, "R1", "row_idx after reset", int'(row_idx), 0);
        check(seg_latch == 1'b1, "R1", "seg_latch after reset", int'(seg_latch), 1);
        check(frame_inv == 1'b0, "R1", "frame_inv after reset", int'(frame_inv), 0);
        check(blink_on == 1'b0, "R1", "blink_on after reset", int'(blink_on), 0);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<195000", cyc);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; duty_nine = 0;
        repeat (3) step();
        check_reset_state();
        rst_n = 1;
        prev_inv = frame_inv; prev_blk = blink_on;

        // seventeen-common duty: frame length and blink period (R5, R8)
        frame_len = 1088; blink_len = 1088 * 32; meas_req = "R5";
        last_inv_cyc = cyc; last_blk_cyc = cyc;
        repeat (70000) step();

        // nine-common duty (R6)
        duty_nine = 1;
        frame_len = 576; blink_len = 576 * 32; meas_req = "R6";
        last_inv_cyc = -1; last_blk_cyc = -1;
        repeat (40000) step();

        // R9: switch to nine-common duty while a high row is active
        frame_len = 0; blink_len = 0;
        duty_nine = 0;
        while (!(row_idx == 5'd12 && !seg_latch)) step();
        duty_nine = 1;
        step();
        while (!seg_latch) step();
        check(row_idx == 5'd0, "R9", "row after early wrap", int'(row_idx), 0);
        check(com_sel == 17'h00001, "R9", "com_sel after early wrap", int'(com_sel), 1);

        // random duty flips and reset pulses, checked by the model
        for (int k = 0; k < 15000; k++) begin
            if ($urandom_range(499) == 0) duty_nine = ~duty_nine;
            if ($urandom_range(2999) == 0) begin
                rst_n = 0;
                repeat ($urandom_range(3, 1)) step();
                check_reset_state();
                rst_n = 1;
            end
            step();
        end

        // R1: reset in the middle of a run
        rst_n = 0;
        step();
        check_reset_state();
        rst_n = 1;
        step();

        summary();
        $finish;
    end
endmodule